// File: doc/BRIEF.md
# Threshold Offset Register Loader

This block keeps the two threshold offsets that a FIFO's almost-empty and almost-full flag logic compares against. It does not hold the FIFO data. Software or a neighbouring controller programs the offsets through the FIFO's own write port. While the active-low load select is held low, each accepted write-clock edge stores the low data bits into one of the two offset registers. A one-bit write pointer picks the register and steps through the empty threshold, then the full threshold, then back to the empty threshold. The same values can be read back through the read port, in the read-clock domain, using a separate one-bit read pointer that follows the same order.

While load select is low, the block withholds the FIFO's normal write and read strobes, so no data word enters or leaves the array. When load select is high, those strobes pass straight through. Both offsets are always available on dedicated outputs for the flag logic. Reset loads each offset with a default that depends on the FIFO depth: 31 up to 256 words, 63 up to 512 words, 127 above that.

Top module: `thresh_ofs_loader`

## Requirements
- R1: After reset, both offsets equal the depth default (127 for the default depth of 1024), the readback bus is all zero, and both pointers select the empty-threshold register.
- R2: With load select low and write enable low, each rising write-clock edge copies wr_data[11:0] into the register the write pointer selects. The pointer then moves on, so that successive loads go to empty, full, empty, full, and so on.
- R3: With load select low and write enable high, a write-clock edge changes neither offset nor the write pointer.
- R4: The write pointer keeps its position while load select is high. Loading only one register leaves the other register at its previous value.
- R5: With load select low and read enable low, each rising read-clock edge places the register chosen by the read pointer on rd_data[11:0] and zero on rd_data[17:12]. The read pointer then advances in the order empty, full, empty.
- R6: With load select low and read enable high, or with load select high, the readback bus and the read pointer hold their values.
- R7: While load select is low, fifo_wr_ok and fifo_rd_ok are both 0. While load select is high, fifo_wr_ok equals the inverse of wr_en_n and fifo_rd_ok equals the inverse of rd_en_n.
- R8: Write-clock edges with load select high never change either offset.
- R9: The read pointer moves independently of the write pointer. After reset, the first readback returns the empty threshold no matter how many loads came before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-side clock |
| rd_clk | input | 1 | Read-side clock |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| ofs_load_n | input | 1 | Active-low select: offset access instead of FIFO data |
| wr_en_n | input | 1 | Active-low write enable of the FIFO port |
| rd_en_n | input | 1 | Active-low read enable of the FIFO port |
| wr_data | input | 18 | FIFO write data; bits 11:0 carry an offset value |
| fifo_wr_ok | output | 1 | Gated write strobe to the FIFO array |
| fifo_rd_ok | output | 1 | Gated read strobe to the FIFO array |
| rd_data | output | 18 | Offset readback, held between reads |
| empty_ofs | output | 12 | Current almost-empty threshold |
| full_ofs | output | 12 | Current almost-full threshold |

## Verification
A write pointer that is stuck or out of step sends the next load to the wrong register. This shows on empty_ofs or full_ofs one write-clock cycle after the load. A read pointer in the wrong state shows on rd_data at the next accepted read edge. Gating faults show at once on fifo_wr_ok and fifo_rd_ok, without waiting for a clock. The bench mixes directed loads that cross the pointer wrap with random accesses in which load select and the enables vary. It compares every result with a model built from the requirements.

// File: rtl/ofs_pkg.sv
`timescale 1ns/1ps
package ofs_pkg;

    typedef enum logic {
        SEL_EMPTY = 1'b0,
        SEL_FULL  = 1'b1
    } ofs_sel_e;

    // Depth-dependent reset value of both threshold registers.
    function automatic int unsigned ofs_default(input int unsigned depth);
        if (depth <= 256)      return 31;
        else if (depth <= 512) return 63;
        else                   return 127;
    endfunction

    function automatic ofs_sel_e sel_next(input ofs_sel_e cur);
        return (cur == SEL_EMPTY) ? SEL_FULL : SEL_EMPTY;
    endfunction

endpackage

// File: rtl/ofs_wr_ctrl.sv
`timescale 1ns/1ps
module ofs_wr_ctrl
    import ofs_pkg::*;
#(
    parameter int unsigned DATA_W      = 18,
    parameter int unsigned OFS_W       = 12,
    parameter int unsigned DEFAULT_OFS = 127
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_n,
    input  logic              wen_n,
    input  logic [DATA_W-1:0] wdata,
    output logic [OFS_W-1:0]  empty_ofs,
    output logic [OFS_W-1:0]  full_ofs
);

    localparam logic [OFS_W-1:0] DEF_V = OFS_W'(DEFAULT_OFS);

    typedef struct packed {
        ofs_sel_e               sel;
        logic [1:0][OFS_W-1:0]  regs;   // index 0 = empty, 1 = full
    } wstate_t;

    wstate_t st_d, st_q;
    logic    load_hit;

    assign load_hit = !load_n && !wen_n;

    always_comb begin
        st_d = st_q;
        if (load_hit) begin
            for (int i = 0; i < 2; i++) begin
                if (int'(st_q.sel) == i) begin
                    st_d.regs[i] = wdata[OFS_W-1:0];
                end
            end
            st_d.sel = sel_next(st_q.sel);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.sel     <= SEL_EMPTY;
            st_q.regs[0] <= DEF_V;
            st_q.regs[1] <= DEF_V;
        end else begin
            st_q <= st_d;
        end
    end

    assign empty_ofs = st_q.regs[0];
    assign full_ofs  = st_q.regs[1];

    p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        load_hit |=> (st_q.sel != $past(st_q.sel)));

    p_blocked_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_n && wen_n) |=> $stable(st_q));

    p_other_kept_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (load_hit && st_q.sel == SEL_EMPTY) |=> $stable(full_ofs));

    p_normal_mode_r8: assert property (@(posedge clk) disable iff (!rst_n)
        load_n |=> ($stable(empty_ofs) && $stable(full_ofs)));

endmodule

// File: rtl/ofs_rd_ctrl.sv
`timescale 1ns/1ps
module ofs_rd_ctrl
    import ofs_pkg::*;
#(
    parameter int unsigned DATA_W = 18,
    parameter int unsigned OFS_W  = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_n,
    input  logic              ren_n,
    input  logic [OFS_W-1:0]  empty_ofs,
    input  logic [OFS_W-1:0]  full_ofs,
    output logic [DATA_W-1:0] rd_data
);

    localparam int unsigned PAD_W = DATA_W - OFS_W;

    typedef struct packed {
        ofs_sel_e          sel;
        logic [DATA_W-1:0] data;
    } rstate_t;

    rstate_t           st_d, st_q;
    logic [DATA_W-1:0] pick;
    logic              read_hit;

    assign read_hit = !load_n && !ren_n;

    generate
        if (PAD_W > 0) begin : g_pad
            assign pick = {{PAD_W{1'b0}},
                           (st_q.sel == SEL_FULL) ? full_ofs : empty_ofs};
        end else begin : g_nopad
            assign pick = (st_q.sel == SEL_FULL) ? full_ofs : empty_ofs;
        end
    endgenerate

    always_comb begin
        st_d = st_q;
        if (read_hit) begin
            st_d.data = pick;
            st_d.sel  = sel_next(st_q.sel);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.sel  <= SEL_EMPTY;
            st_q.data <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_data = st_q.data;

    p_rd_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        read_hit |=> (st_q.sel != $past(st_q.sel)));

    p_rd_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (load_n || ren_n) |=> $stable(st_q));

endmodule

// File: rtl/ofs_port_gate.sv
`timescale 1ns/1ps
module ofs_port_gate (
    input  logic load_n,
    input  logic wen_n,
    input  logic ren_n,
    output logic fifo_wr_ok,
    output logic fifo_rd_ok
);

    always_comb begin
        fifo_wr_ok = load_n && !wen_n;
        fifo_rd_ok = load_n && !ren_n;
    end

endmodule

// File: rtl/thresh_ofs_loader.sv
`timescale 1ns/1ps
module thresh_ofs_loader
    import ofs_pkg::*;
#(
    parameter int unsigned DATA_W = 18,
    parameter int unsigned OFS_W  = 12,
    parameter int unsigned DEPTH  = 1024
) (
    input  logic              wr_clk,
    input  logic              rd_clk,
    input  logic              rst_n,
    input  logic              ofs_load_n,
    input  logic              wr_en_n,
    input  logic              rd_en_n,
    input  logic [DATA_W-1:0] wr_data,
    output logic              fifo_wr_ok,
    output logic              fifo_rd_ok,
    output logic [DATA_W-1:0] rd_data,
    output logic [OFS_W-1:0]  empty_ofs,
    output logic [OFS_W-1:0]  full_ofs
);

    localparam int unsigned DEF_OFS = ofs_default(DEPTH);

    ofs_wr_ctrl #(
        .DATA_W      (DATA_W),
        .OFS_W       (OFS_W),
        .DEFAULT_OFS (DEF_OFS)
    ) u_wr (
        .clk       (wr_clk),
        .rst_n     (rst_n),
        .load_n    (ofs_load_n),
        .wen_n     (wr_en_n),
        .wdata     (wr_data),
        .empty_ofs (empty_ofs),
        .full_ofs  (full_ofs)
    );

    ofs_rd_ctrl #(
        .DATA_W (DATA_W),
        .OFS_W  (OFS_W)
    ) u_rd (
        .clk       (rd_clk),
        .rst_n     (rst_n),
        .load_n    (ofs_load_n),
        .ren_n     (rd_en_n),
        .empty_ofs (empty_ofs),
        .full_ofs  (full_ofs),
        .rd_data   (rd_data)
    );

    ofs_port_gate u_gate (
        .load_n     (ofs_load_n),
        .wen_n      (wr_en_n),
        .ren_n      (rd_en_n),
        .fifo_wr_ok (fifo_wr_ok),
        .fifo_rd_ok (fifo_rd_ok)
    );

    p_quiet_wr_r7: assert property (@(posedge wr_clk) disable iff (!rst_n)
        !ofs_load_n |-> !fifo_wr_ok);

    p_quiet_rd_r7: assert property (@(posedge rd_clk) disable iff (!rst_n)
        !ofs_load_n |-> !fifo_rd_ok);

    // R5: readback is only defined when no offset load happens at the same time.
    p_excl_access_r5: assert property (@(posedge wr_clk) disable iff (!rst_n)
        !(!ofs_load_n && !wr_en_n && !rd_en_n));

endmodule

// File: tb/tb_thresh_ofs_loader.sv
`timescale 1ns/1ps
module tb_thresh_ofs_loader;

    localparam int DATA_W = 18;
    localparam int OFS_W  = 12;
    localparam int DEPTH  = 1024;

    logic              wr_clk = 1'b0;
    logic              rd_clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              ofs_load_n = 1'b1;
    logic              wr_en_n = 1'b1;
    logic              rd_en_n = 1'b1;
    logic [DATA_W-1:0] wr_data = '0;
    logic              fifo_wr_ok, fifo_rd_ok;
    logic [DATA_W-1:0] rd_data;
    logic [OFS_W-1:0]  empty_ofs, full_ofs;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 0;

    // bench model
    logic [OFS_W-1:0] m_reg [2];
    int               m_wptr, m_rptr;
    logic [DATA_W-1:0] m_rd;

    thresh_ofs_loader #(.DATA_W(DATA_W), .OFS_W(OFS_W), .DEPTH(DEPTH)) dut (
        .wr_clk(wr_clk), .rd_clk(rd_clk), .rst_n(rst_n),
        .ofs_load_n(ofs_load_n), .wr_en_n(wr_en_n), .rd_en_n(rd_en_n),
        .wr_data(wr_data), .fifo_wr_ok(fifo_wr_ok), .fifo_rd_ok(fifo_rd_ok),
        .rd_data(rd_data), .empty_ofs(empty_ofs), .full_ofs(full_ofs)
    );

    always #2.5 wr_clk = ~wr_clk;
    initial begin
        #1.25;
        forever #2.5 rd_clk = ~rd_clk;
    end

    function automatic int exp_default(input int depth);
        if (depth <= 256) return 31;
        if (depth <= 512) return 63;
        return 127;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic summary();
        if (!done) begin
            done = 1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        end
        $finish;
    endtask

    // One write-port cycle; checks gating (R7) and resulting offsets.
    task automatic wr_op(input logic ld_n, input logic we_n, input logic [DATA_W-1:0] d,
                         input string req);
        @(negedge wr_clk);
        ofs_load_n = ld_n; wr_en_n = we_n; rd_en_n = 1'b1; wr_data = d;
        #0.5;
        chk("R7 fifo_wr_ok", {31'b0, fifo_wr_ok}, {31'b0, ld_n && !we_n});
        @(posedge wr_clk);
        if (!ld_n && !we_n) begin
            m_reg[m_wptr] = d[OFS_W-1:0];
            m_wptr = 1 - m_wptr;
        end
        @(negedge wr_clk);
        chk({req, " empty_ofs"}, 32'(empty_ofs), 32'(m_reg[0]));
        chk({req, " full_ofs"},  32'(full_ofs),  32'(m_reg[1]));
        ofs_load_n = 1'b1; wr_en_n = 1'b1;
    endtask

    // One read-port cycle; checks gating (R7) and readback bus.
    task automatic rd_op(input logic ld_n, input logic re_n, input string req);
        @(negedge rd_clk);
        ofs_load_n = ld_n; rd_en_n = re_n; wr_en_n = 1'b1;
        #0.5;
        chk("R7 fifo_rd_ok", {31'b0, fifo_rd_ok}, {31'b0, ld_n && !re_n});
        @(posedge rd_clk);
        if (!ld_n && !re_n) begin
            m_rd = '0;
            m_rd[OFS_W-1:0] = m_reg[m_rptr];
            m_rptr = 1 - m_rptr;
        end
        @(negedge rd_clk);
        chk({req, " rd_data"}, 32'(rd_data), 32'(m_rd));
        ofs_load_n = 1'b1; rd_en_n = 1'b1;
    endtask

    initial begin
        #(5.0 * 150000);
        n_bad++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        int seed;
        seed = 32'h1F0C_A5E7;
        void'($urandom(seed));
        m_reg[0] = OFS_W'(exp_default(DEPTH));
        m_reg[1] = OFS_W'(exp_default(DEPTH));
        m_wptr = 0; m_rptr = 0; m_rd = '0;

        repeat (3) @(negedge wr_clk);
        rst_n = 1'b1;
        @(negedge wr_clk);
        // R1: reset state
        chk("R1 empty_ofs", 32'(empty_ofs), 32'd127);
        chk("R1 full_ofs",  32'(full_ofs),  32'd127);
        chk("R1 rd_data",   32'(rd_data),   32'd0);

        // R2: load order empty, full, empty; upper data bits discarded
        wr_op(1'b0, 1'b0, 18'h3_0ABC, "R2 load1");
        wr_op(1'b0, 1'b0, 18'h2_F123, "R2 load2");
        wr_op(1'b0, 1'b0, 18'h0_0456, "R2 load3");
        // R3: load select low, enable high: nothing changes
        wr_op(1'b0, 1'b1, 18'h0_0FFF, "R3 blocked");
        // R8: normal mode writes leave offsets alone
        wr_op(1'b1, 1'b0, 18'h0_0777, "R8 normal");
        wr_op(1'b1, 1'b1, 18'h0_0555, "R8 idle");
        // R4: pointer kept across deassertion -> this goes to full only
        wr_op(1'b0, 1'b0, 18'h1_0321, "R4 resume");
        // R9: read pointer independent: first read gives empty register
        rd_op(1'b0, 1'b0, "R9 first read");
        rd_op(1'b0, 1'b1, "R6 hold");
        rd_op(1'b1, 1'b0, "R6 normal");
        rd_op(1'b0, 1'b0, "R5 second read");
        rd_op(1'b0, 1'b0, "R5 wrap read");

        for (int i = 0; i < 400; i++) begin
            logic ld, en;
            ld = ($urandom % 3) == 0;
            en = $urandom % 2;
            if ($urandom % 2)
                wr_op(ld, en, DATA_W'($urandom), "R2 random write");
            else
                rd_op(ld, en, "R5 random read");
        end

        summary();
    end

endmodule